// File: doc/BRIEF.md
# Chained Transfer Descriptor Loader

This block walks a linked list of transfer descriptors on behalf of one copy channel. On a start request it latches the channel's descriptor pointer and reads four consecutive 32-bit words from memory through a read port that holds one request open at a time. The four words are a control word, a source address, a destination address and the pointer to the next descriptor.

When the fourth word has returned, the block raises a one-cycle load strobe. In that cycle it presents replacement values for the channel's control/status register, size register, source and destination address registers and descriptor pointer, along with the address of the descriptor just read. The control/status value keeps every bit of the live register except four transfer flags, which are taken from the descriptor. The size value keeps every bit except the total-size field. A chain flag tells the channel whether another descriptor follows once the current transfer has finished.

Top module: `ll_desc_fetch`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o` and `load_o` are all low.
- R2: A fetch issues exactly four reads at base+0x0, base+0x4, base+0x8 and base+0xC, in that order, where base is the `desc_ptr_i` value sampled with the start. `rd_req_o` and `rd_addr_o` stay unchanged until `rd_ack_i` accepts the read.
- R3: `load_o` is high for exactly one cycle, the cycle right after the clock edge that accepts the fourth read.
- R4: `busy_o` rises on the edge that accepts `start_i` and stays high through the `load_o` cycle. It is low in the cycle after that.
- R5: `ch_csr_o` equals `ch_csr_i` with bits [7:4] replaced by control-word bits [19:16]: source increment to 4, destination increment to 5, source select to 6, destination select to 7.
- R6: `ch_sz_o` equals `ch_sz_i` with bits [11:0] replaced by the control-word total-size field [11:0]. Bits [31:12] are unchanged.
- R7: `ch_src_o` and `ch_dst_o` equal the words read at offsets 0x4 and 0x8.
- R8: `cur_desc_o` equals the base sampled at start, and `desc_ptr_o` equals the word read at offset 0xC.
- R9: `chain_o` is the inverse of control-word bit 20, the end-of-list flag.
- R10: A start pulse while `busy_o` is high is ignored. The base and the read addresses do not change, and no extra load strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to fetch the descriptor at `desc_ptr_i` |
| desc_ptr_i | input | 32 | Channel descriptor pointer register |
| ch_csr_i | input | 32 | Live channel control/status register |
| ch_sz_i | input | 32 | Live channel size register |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | 32 | Read byte address |
| rd_ack_i | input | 1 | Read accepted, data valid on `rd_data_i` |
| rd_data_i | input | 32 | Read data |
| busy_o | output | 1 | Fetch in progress |
| load_o | output | 1 | One-cycle strobe: channel registers take the values below |
| ch_csr_o | output | 32 | New control/status value |
| ch_sz_o | output | 32 | New size value |
| ch_src_o | output | 32 | New source address |
| ch_dst_o | output | 32 | New destination address |
| cur_desc_o | output | 32 | Address of the descriptor just fetched |
| desc_ptr_o | output | 32 | New descriptor pointer (next link) |
| chain_o | output | 1 | High when another descriptor follows |

## Verification
The assertions assume that `rd_ack_i` is only raised while `rd_req_o` is high, that read data is valid in the same cycle as the acknowledge, and that `ch_csr_i` and `ch_sz_i` do not change during a fetch. The bench's memory responder is written inside the same negedge loop that samples the outputs. It only acknowledges an open request, after a per-vector wait of zero to three cycles, and it returns words computed from the latched base. The channel inputs are set once, together with the start pulse.

// File: rtl/ll_desc_pkg.sv
package ll_desc_pkg;
  localparam int DW         = 32;
  localparam int NWORDS     = 4;
  localparam int IDXW       = $clog2(NWORDS);
  localparam int WORD_BYTES = DW / 8;
  localparam int TOT_W      = 12;
  localparam int NFLAGS     = 4;
  localparam int FLAG_DESC  = 16;
  localparam int FLAG_CSR   = 4;
  localparam int EOL_BIT    = 20;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DONE} fetch_st_t;
  typedef enum logic [IDXW-1:0] {W_CTRL, W_SRC, W_DST, W_NEXT} word_idx_t;

  function automatic logic [DW-1:0] word_addr(input logic [DW-1:0] base,
                                              input logic [IDXW-1:0] idx);
    return base + DW'(idx) * DW'(WORD_BYTES);
  endfunction

  function automatic logic [DW-1:0] merge_csr(input logic [DW-1:0] csr,
                                              input logic [NFLAGS-1:0] flags);
    logic [DW-1:0] field;
    field = DW'({NFLAGS{1'b1}}) << FLAG_CSR;
    return (csr & ~field) | (DW'(flags) << FLAG_CSR);
  endfunction

  function automatic logic [DW-1:0] merge_sz(input logic [DW-1:0] sz,
                                             input logic [TOT_W-1:0] total);
    return (sz & ~DW'({TOT_W{1'b1}})) | DW'(total);
  endfunction
endpackage

// File: rtl/ll_desc_seq.sv
module ll_desc_seq
  import ll_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DW-1:0]     ptr_i,
  output logic              rd_req_o,
  output logic [DW-1:0]     rd_addr_o,
  input  logic              rd_ack_i,
  output logic [NWORDS-1:0] word_we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DW-1:0]     base_o
);
  fetch_st_t       st_q;
  logic [IDXW-1:0] idx_q;
  logic [DW-1:0]   base_q;
  logic            accept;
  logic            last_word;

  assign accept    = (st_q == S_FETCH) && rd_ack_i;
  assign last_word = (idx_q == IDXW'(NWORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      base_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          base_q <= ptr_i;
          idx_q  <= '0;
          st_q   <= S_FETCH;
        end
        S_FETCH: if (accept) begin
          if (last_word) st_q  <= S_DONE;
          else           idx_q <= idx_q + 1'b1;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (st_q == S_FETCH);
  assign rd_addr_o = word_addr(base_q, idx_q);
  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = (st_q == S_DONE);
  assign base_o    = base_q;

  for (genvar g = 0; g < NWORDS; g++) begin : g_we
    assign word_we_o[g] = accept && (idx_q == IDXW'(g));
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o))); // R2
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_we_o)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(base_q)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
endmodule

// File: rtl/ll_desc_capture.sv
module ll_desc_capture
  import ll_desc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NWORDS-1:0]         we_i,
  input  logic [DW-1:0]             data_i,
  output logic [NWORDS-1:0][DW-1:0] words_o
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       words_o[g] <= '0;
      else if (we_i[g]) words_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/ll_desc_merge.sv
module ll_desc_merge
  import ll_desc_pkg::*;
(
  input  logic [DW-1:0]             csr_i,
  input  logic [DW-1:0]             sz_i,
  input  logic [NWORDS-1:0][DW-1:0] words_i,
  output logic [DW-1:0]             csr_o,
  output logic [DW-1:0]             sz_o,
  output logic [DW-1:0]             src_o,
  output logic [DW-1:0]             dst_o,
  output logic [DW-1:0]             next_o,
  output logic                      chain_o
);
  logic [DW-1:0] ctrl;

  assign ctrl    = words_i[W_CTRL];
  assign csr_o   = merge_csr(csr_i, ctrl[FLAG_DESC +: NFLAGS]);
  assign sz_o    = merge_sz(sz_i, ctrl[TOT_W-1:0]);
  assign src_o   = words_i[W_SRC];
  assign dst_o   = words_i[W_DST];
  assign next_o  = words_i[W_NEXT];
  assign chain_o = !ctrl[EOL_BIT];
endmodule

// File: rtl/ll_desc_fetch.sv
module ll_desc_fetch
  import ll_desc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] desc_ptr_i,
  input  logic [DW-1:0] ch_csr_i,
  input  logic [DW-1:0] ch_sz_i,
  output logic          rd_req_o,
  output logic [DW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          load_o,
  output logic [DW-1:0] ch_csr_o,
  output logic [DW-1:0] ch_sz_o,
  output logic [DW-1:0] ch_src_o,
  output logic [DW-1:0] ch_dst_o,
  output logic [DW-1:0] cur_desc_o,
  output logic [DW-1:0] desc_ptr_o,
  output logic          chain_o
);
  logic [NWORDS-1:0]         word_we;
  logic [NWORDS-1:0][DW-1:0] words;

  ll_desc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ptr_i     (desc_ptr_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_ack_i  (rd_ack_i),
    .word_we_o (word_we),
    .busy_o    (busy_o),
    .done_o    (load_o),
    .base_o    (cur_desc_o)
  );

  ll_desc_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (word_we),
    .data_i  (rd_data_i),
    .words_o (words)
  );

  ll_desc_merge u_merge (
    .csr_i   (ch_csr_i),
    .sz_i    (ch_sz_i),
    .words_i (words),
    .csr_o   (ch_csr_o),
    .sz_o    (ch_sz_o),
    .src_o   (ch_src_o),
    .dst_o   (ch_dst_o),
    .next_o  (desc_ptr_o),
    .chain_o (chain_o)
  );

  AST_LOAD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> $past(word_we[NWORDS-1])); // R3
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> busy_o); // R4
  AST_NEXT_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    word_we[NWORDS-1] |=> (desc_ptr_o == $past(rd_data_i))); // R8
endmodule

// File: tb/ll_desc_fetch_tb.sv
`timescale 1ns/1ps
module ll_desc_fetch_tb;
  typedef struct packed {
    logic [31:0] ptr;
    logic [31:0] ctrl;
    logic [31:0] csr_in;
    logic [31:0] sz_in;
    logic [31:0] exp_csr;
    logic [31:0] exp_sz;
    logic        exp_chain;
    logic [2:0]  lat;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VEC [NVEC] = '{
    '{32'h0000_1000, 32'h0005_0010, 32'hFFFF_FFFF, 32'h0040_0000, 32'hFFFF_FF5F, 32'h0040_0010, 1'b1, 3'd0},
    '{32'h0000_2040, 32'h001A_0FFF, 32'h0000_0001, 32'h1234_5678, 32'h0000_00A1, 32'h1234_5FFF, 1'b0, 3'd2},
    '{32'h0000_FFF0, 32'h000F_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_00F0, 32'hFFFF_F000, 1'b1, 3'd1},
    '{32'h0000_0000, 32'hFFF0_F123, 32'h0000_00F0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0123, 1'b0, 3'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] desc_ptr_i = '0;
  logic [31:0] ch_csr_i = '0;
  logic [31:0] ch_sz_i = '0;
  logic        rd_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        rd_req_o, busy_o, load_o, chain_o;
  logic [31:0] rd_addr_o, ch_csr_o, ch_sz_o, ch_src_o, ch_dst_o, cur_desc_o, desc_ptr_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ll_desc_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .desc_ptr_i(desc_ptr_i),
    .ch_csr_i(ch_csr_i), .ch_sz_i(ch_sz_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .load_o(load_o), .ch_csr_o(ch_csr_o), .ch_sz_o(ch_sz_o),
    .ch_src_o(ch_src_o), .ch_dst_o(ch_dst_o), .cur_desc_o(cur_desc_o),
    .desc_ptr_o(desc_ptr_o), .chain_o(chain_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] src_of(input logic [31:0] b); return b ^ 32'h5A5A_0000; endfunction
  function automatic logic [31:0] dst_of(input logic [31:0] b); return b + 32'h0008_0000; endfunction
  function automatic logic [31:0] nxt_of(input logic [31:0] b); return b + 32'h0000_0100; endfunction

  task automatic run_fetch(input vec_t v, input bit restart);
    logic [31:0] addr_log [4];
    int acks = 0, wait_c = 0, done_cnt = 0, done_n = -1, last_ack_n = -2;
    int busy_err = 0, stab_err = 0;
    bit prev_wait = 0, finished = 0;
    logic [31:0] prev_addr = '0;
    logic [31:0] word;
    for (int k = 0; k < 4; k++) addr_log[k] = 32'hFFFF_FFFF;
    @(negedge clk);
    start_i = 1'b1; desc_ptr_i = v.ptr; ch_csr_i = v.csr_in; ch_sz_i = v.sz_in; rd_ack_i = 1'b0;
    for (int n = 1; n < 80 && !finished; n++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (restart && n == 3) begin
        start_i = 1'b1;
        desc_ptr_i = v.ptr + 32'h0000_0800;
      end
      if (done_cnt > 0) begin
        check("R4 busy low after load", {31'd0, busy_o}, 32'd0);
        check("R3 load single cycle", {31'd0, load_o}, 32'd0);
        finished = 1;
      end else if (load_o) begin
        done_cnt++;
        done_n = n;
        check("R4 busy during load", {31'd0, busy_o}, 32'd1);
        check("R5 csr merge", ch_csr_o, v.exp_csr);
        check("R6 size merge", ch_sz_o, v.exp_sz);
        check("R7 source", ch_src_o, src_of(v.ptr));
        check("R7 destination", ch_dst_o, dst_of(v.ptr));
        check("R8 current descriptor", cur_desc_o, v.ptr);
        check("R8 next pointer", desc_ptr_o, nxt_of(v.ptr));
        check("R9 chain flag", {31'd0, chain_o}, {31'd0, v.exp_chain});
      end else if (!busy_o) busy_err++;
      if (prev_wait && rd_req_o && rd_addr_o != prev_addr) stab_err++;
      rd_ack_i = 1'b0;
      prev_wait = 0;
      if (rd_req_o && !finished) begin
        if (wait_c >= int'(v.lat)) begin
          case (rd_addr_o - v.ptr)
            32'h0:   word = v.ctrl;
            32'h4:   word = src_of(v.ptr);
            32'h8:   word = dst_of(v.ptr);
            32'hC:   word = nxt_of(v.ptr);
            default: word = 32'hDEAD_BEEF;
          endcase
          rd_ack_i = 1'b1;
          rd_data_i = word;
          if (acks < 4) addr_log[acks] = rd_addr_o;
          acks++;
          last_ack_n = n;
          wait_c = 0;
        end else begin
          wait_c++;
          prev_wait = 1;
          prev_addr = rd_addr_o;
        end
      end
    end
    rd_ack_i = 1'b0;
    check("R3 load strobe count", done_cnt, 1);
    check("R3 load one cycle after last read", done_n, last_ack_n + 1);
    check("R2 read count", acks, 4);
    for (int k = 0; k < 4; k++)
      check("R2 read address order", addr_log[k], v.ptr + 32'(4 * k));
    check("R2 address held while waiting", stab_err, 0);
    check("R4 busy from start to load", busy_err, 0);
    if (restart) begin
      check("R10 restart ignored, base kept", cur_desc_o, v.ptr);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'd0, busy_o}, 32'd0);
    check("R1 req in reset", {31'd0, rd_req_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", {31'd0, busy_o}, 32'd0);
    check("R1 req after reset", {31'd0, rd_req_o}, 32'd0);
    check("R1 load after reset", {31'd0, load_o}, 32'd0);
    for (int i = 0; i < NVEC; i++) run_fetch(VEC[i], 1'b0);
    run_fetch(VEC[1], 1'b1);
    run_fetch(VEC[0], 1'b1);
    repeat (2) @(negedge clk);
    check("R1 idle between fetches", {31'd0, rd_req_o}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule